// File: doc/BRIEF.md
# Standby Clock Gating Controller

This block decides when the core pipeline clock is stopped for low-power standby and when it starts again. The pipeline reports, with a one-cycle strobe, that a wait instruction has retired from its last stage. At that moment the controller looks at the system bus. If the bus is idle and no wake source is pending, it drops the core clock enable on the next register boundary and raises a standby flag. If the bus is busy, the wait does nothing and the core keeps running. In both cases a wait that retires while the core is awake produces a one-cycle pulse that sets the interrupt enable.

The controller itself runs on the always-on clock, with the timer and the interrupt and reset input logic. While the core is stopped, any external interrupt line or the non-maskable interrupt wakes it. The internal timer interrupt also wakes it, unless the mode configuration has disabled that interrupt. Reset always returns the block to the awake state. The gate cell that consumes the enable and the pipeline itself are outside this block. All control and status pins are plain level signals, and every input is expected to be synchronous to the always-on clock.

Top module: `standby_gate_ctl`

## Requirements
- R1: The clock enable and standby flag change only at a rising clock edge. They never leave the awake state unless `wait_done_i` was high at that edge.
- R2: When `wait_done_i` and `bus_idle_i` are both high at an edge while awake and no wake source is active, `core_clk_en_o` is low from that edge on.
- R3: When `wait_done_i` is high and `bus_idle_i` is low, the wait is a no-op: `core_clk_en_o` stays high and `standby_o` stays low.
- R4: Every wait that retires while awake, whether or not the bus is idle, makes `ie_set_o` high for exactly the one cycle after that edge.
- R5: While in standby, any bit of `irq_i` or a high `nmi_i` sets `core_clk_en_o` high at the next edge.
- R6: While in standby, `timer_irq_i` wakes the core at the next edge when `timer_wake_dis_i` is 0. It has no effect when `timer_wake_dis_i` is 1.
- R7: `standby_o` is high exactly when `core_clk_en_o` is low.
- R8: Reset (`rst_n` low) forces `core_clk_en_o` high, `standby_o` low and `ie_set_o` low, including when reset arrives during standby.
- R9: If a wake source is active in the same cycle a wait retires with the bus idle, standby is not entered. The interrupt-enable pulse still occurs.
- R10: A `wait_done_i` strobe while already in standby is ignored: it produces no `ie_set_o` pulse and does not keep the core asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| wait_done_i | input | 1 | Wait instruction retired this cycle |
| bus_idle_i | input | 1 | System bus has no transaction in flight |
| irq_i | input | NUM_IRQ | External interrupt lines, active high |
| nmi_i | input | 1 | Non-maskable interrupt, active high |
| timer_irq_i | input | 1 | Internal timer interrupt |
| timer_wake_dis_i | input | 1 | Mode setting: 1 stops the timer interrupt from waking |
| core_clk_en_o | output | 1 | Enable for the core clock gate |
| standby_o | output | 1 | High while the core clock is stopped |
| ie_set_o | output | 1 | One-cycle pulse that sets the interrupt enable |

## Verification
The bench sends a wait over a busy bus. A design that ignored the idle test would put the core to sleep while a transfer is still open. It wakes the core from each interrupt line on its own and from the non-maskable input. A design that reduced only some of the lines would leave the core asleep for good. It raises the timer interrupt with the disable bit both clear and set, which catches a controller that ignores the mode setting. It also retires a wait together with a pending interrupt, and strobes a wait during standby. A design that slept on a pending wake, or that pulsed the interrupt enable from a frozen pipeline, fails these checks.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [0:0] {
    ST_AWAKE = 1'b0,
    ST_SLEEP = 1'b1
  } stby_state_t;
endpackage

// File: rtl/standby_wake_src.sv
// Combines all wake sources into one level; the timer is qualified by the mode bit.
module standby_wake_src #(
  parameter int NUM_IRQ = 6
) (
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               timer_irq_i,
  input  logic               timer_wake_dis_i,
  output logic               wake_o
);
  logic [NUM_IRQ:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_or
    assign chain[g+1] = chain[g] | irq_i[g];
  end
  assign wake_o = chain[NUM_IRQ] | nmi_i | (timer_irq_i & ~timer_wake_dis_i);
endmodule

// File: rtl/standby_fsm.sv
// Two-state controller; enable and status are separate registers.
module standby_fsm
  import standby_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_done_i,
  input  logic bus_idle_i,
  input  logic wake_i,
  output logic accept_o,
  output logic clk_en_o,
  output logic stby_o
);
  stby_state_t state_q, state_d;
  logic        clk_en_q, stby_q;

  assign accept_o = (state_q == ST_AWAKE) && wait_done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE: if (accept_o && bus_idle_i && !wake_i) state_d = ST_SLEEP;
      ST_SLEEP: if (wake_i) state_d = ST_AWAKE;
      default:  state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_AWAKE;
      clk_en_q <= 1'b1;
      stby_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      clk_en_q <= (state_d == ST_AWAKE);
      stby_q   <= (state_d == ST_SLEEP);
    end
  end

  assign clk_en_o = clk_en_q;
  assign stby_o   = stby_q;
endmodule

// File: rtl/standby_ie_pulse.sv
module standby_ie_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  output logic ie_set_o
);
  logic pulse_q;
  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= accept_i;
  end
  assign ie_set_o = pulse_q;
endmodule

// File: rtl/standby_gate_ctl.sv
module standby_gate_ctl #(
  parameter int NUM_IRQ = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wait_done_i,
  input  logic               bus_idle_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               timer_irq_i,
  input  logic               timer_wake_dis_i,
  output logic               core_clk_en_o,
  output logic               standby_o,
  output logic               ie_set_o
);
  logic wake, accept;

  standby_wake_src #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_i(irq_i), .nmi_i(nmi_i), .timer_irq_i(timer_irq_i),
    .timer_wake_dis_i(timer_wake_dis_i), .wake_o(wake)
  );

  standby_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wait_done_i(wait_done_i), .bus_idle_i(bus_idle_i),
    .wake_i(wake), .accept_o(accept), .clk_en_o(core_clk_en_o), .stby_o(standby_o)
  );

  standby_ie_pulse u_ie (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .ie_set_o(ie_set_o)
  );
endmodule

// File: rtl/standby_gate_ctl_chk.sv
module standby_gate_ctl_chk #(
  parameter int NUM_IRQ = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wait_done_i,
  input logic               bus_idle_i,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic               nmi_i,
  input logic               timer_irq_i,
  input logic               timer_wake_dis_i,
  input logic               core_clk_en_o,
  input logic               standby_o,
  input logic               ie_set_o
);
  logic any_wake;
  assign any_wake = (|irq_i) | nmi_i | (timer_irq_i & ~timer_wake_dis_i);

  p_stay_awake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en_o && !wait_done_i |=> core_clk_en_o);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en_o && wait_done_i && bus_idle_i && !any_wake |=> !core_clk_en_o);
  p_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en_o && wait_done_i && !bus_idle_i |=> core_clk_en_o);
  p_ie_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en_o && wait_done_i |=> ie_set_o);
  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en_o && ((|irq_i) || nmi_i) |=> core_clk_en_o);
  p_timer_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en_o && !any_wake |=> !core_clk_en_o);
  p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o == !core_clk_en_o);
  p_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en_o && wait_done_i && any_wake |=> core_clk_en_o);
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en_o |=> !ie_set_o);
endmodule

bind standby_gate_ctl standby_gate_ctl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/standby_gate_ctl_bench.sv
module standby_gate_ctl_bench;
  localparam int NIRQ = 6;
  logic clk = 1'b0;
  logic rst_n, wait_done, bus_idle, nmi, timer_irq, timer_dis;
  logic [NIRQ-1:0] irq;
  logic clk_en, stby, ie_set;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  standby_gate_ctl #(.NUM_IRQ(NIRQ)) u_standby_gate_ctl (
    .clk(clk), .rst_n(rst_n), .wait_done_i(wait_done), .bus_idle_i(bus_idle),
    .irq_i(irq), .nmi_i(nmi), .timer_irq_i(timer_irq), .timer_wake_dis_i(timer_dis),
    .core_clk_en_o(clk_en), .standby_o(stby), .ie_set_o(ie_set)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic quiet();
    wait_done = 0; bus_idle = 1; irq = '0; nmi = 0; timer_irq = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go_sleep();
    wait_done = 1; bus_idle = 1; tick(); wait_done = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; quiet(); timer_dis = 0;
    repeat (3) tick();
    chk(clk_en, 1, "R8 reset clk_en");
    chk(stby, 0, "R8 reset standby");
    chk(ie_set, 0, "R8 reset ie_set");
    rst_n = 1; repeat (4) tick();
    chk(clk_en, 1, "R1 no wait stays awake");
  endtask

  task automatic t_enter();
    go_sleep();
    chk(clk_en, 0, "R2 enter standby");
    chk(stby, 1, "R7 standby high while asleep");
    chk(ie_set, 1, "R4 ie_set pulse on entry");
    tick();
    chk(ie_set, 0, "R4 ie_set single cycle");
    chk(clk_en, 0, "R2 stays asleep");
  endtask

  task automatic t_noop();
    wait_done = 1; bus_idle = 0; tick(); wait_done = 0; bus_idle = 1;
    chk(clk_en, 1, "R3 busy bus no-op clk_en");
    chk(stby, 0, "R3 busy bus no-op standby");
    chk(ie_set, 1, "R4 ie_set on no-op wait");
    tick();
    chk(ie_set, 0, "R4 ie_set cleared");
  endtask

  task automatic t_irq_lines();
    for (int i = 0; i < NIRQ; i++) begin
      go_sleep(); tick();
      irq = NIRQ'(1) << i; tick(); irq = '0;
      chk(clk_en, 1, $sformatf("R5 irq line %0d wakes", i));
      chk(stby, 0, "R7 standby low after wake");
    end
  endtask

  task automatic t_nmi();
    go_sleep();
    nmi = 1; tick(); nmi = 0;
    chk(clk_en, 1, "R5 nmi wakes");
  endtask

  task automatic t_timer();
    timer_dis = 0; go_sleep();
    timer_irq = 1; tick(); timer_irq = 0;
    chk(clk_en, 1, "R6 timer wakes when enabled");
    timer_dis = 1; go_sleep();
    timer_irq = 1; tick(); tick();
    chk(clk_en, 0, "R6 disabled timer ignored");
    chk(stby, 1, "R6 disabled timer standby held");
    timer_irq = 0; irq[0] = 1; tick(); irq = '0; timer_dis = 0;
    chk(clk_en, 1, "R5 irq wakes after masked timer");
  endtask

  task automatic t_pending();
    wait_done = 1; bus_idle = 1; irq[2] = 1; tick();
    wait_done = 0; irq = '0;
    chk(clk_en, 1, "R9 pending wake blocks standby");
    chk(ie_set, 1, "R9 ie_set still pulses");
    tick();
  endtask

  task automatic t_wait_in_standby();
    go_sleep(); tick();
    wait_done = 1; tick(); wait_done = 0;
    chk(ie_set, 0, "R10 no ie_set in standby");
    chk(clk_en, 0, "R10 still asleep");
    nmi = 1; wait_done = 1; tick(); nmi = 0; wait_done = 0;
    chk(clk_en, 1, "R10 wait strobe does not block wake");
    chk(ie_set, 0, "R10 no ie_set on wake edge");
    tick();
  endtask

  task automatic t_reset_in_standby();
    go_sleep();
    rst_n = 0; tick();
    chk(clk_en, 1, "R8 reset wakes core");
    chk(stby, 0, "R8 reset clears standby");
    rst_n = 1; tick();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_enter();
    irq[1] = 1; tick(); irq = '0;
    t_noop();
    t_irq_lines();
    t_nmi();
    t_timer();
    t_pending();
    t_wait_in_standby();
    t_reset_in_standby();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule